// File: doc/BRIEF.md
# Time-Compressed Parallel Sieve Pipeline

This block scans a range of sieve locations in ascending order and handles `LANES` consecutive locations in every clock cycle. Each cycle in which `go_i` is high, it injects one block of `LANES` locations into a chain of stations. A block carries one accumulator line per location and a base index that is a multiple of `LANES`. Each station holds a small set of arithmetic progressions. A progression is defined by a first hit, an interval and a weight. When the block that contains a progression's next hit passes, the station adds that progression's weight to the line for that location. It then advances the progression past the block.

The work is local and skewed in time. A block moves one station forward per clock, so every station sees each block exactly once and in order. A progression whose interval is `p` acts roughly once every `p/LANES` blocks. When `p` is smaller than `LANES`, one progression can land several hits in the same block. The station resolves up to `MAX_HITS` of them in a single cycle.

After the last station, every line is compared with a threshold. The block's base index is then reported together with a mask of the locations that passed. Software loads the progressions through the configuration port while the pipeline is idle. It then pulses `restart_i` and streams blocks with `go_i`.

Top module: `sieve_pipe_top`

## Requirements
- R1: After reset, `out_valid_o` is low and `out_mask_o` is zero.
- R2: Each cycle with `go_i` high and `restart_i` low injects one block. The first block after reset or restart has base 0, and each later block's base is `LANES` higher than the one before. Exactly one output block appears per injected block.
- R3: A block injected at clock edge t is presented on the outputs right after edge t+`N_STATIONS`.
- R4: A contribution to location a shows up in the block with base a - (a mod `LANES`), at mask bit a mod `LANES`.
- R5: A progression with first hit f, interval p and weight w adds w to every location f + m·p for m ≥ 0. It adds nothing to any other location.
- R6: When p < `LANES`, all hits of a progression inside one block are applied in that block, provided p·`MAX_HITS` ≥ `LANES`.
- R7: Contributions from different progressions, whether in the same station or in different stations, add at the same location.
- R8: Accumulated sums saturate at 2^`ACC_W`-1 and never wrap.
- R9: A location's mask bit is set exactly when its sum is strictly greater than `thresh_i`.
- R10: A configuration write to (`cfg_sta_i`, `cfg_slot_i`) replaces that progression's interval, first hit and weight. It leaves every other slot unchanged. A weight of 0 makes the slot contribute nothing.
- R11: `out_mask_o` is zero in every cycle in which `out_valid_o` is low.
- R12: `restart_i`, asserted with `go_i` low, makes the next injected block start at base 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Progression write strobe |
| cfg_sta_i | input | STA_W | Station selected for the write |
| cfg_slot_i | input | SLOT_W | Progression slot within the station |
| cfg_interval_i | input | IDX_W | Interval p (nonzero) |
| cfg_first_i | input | IDX_W | Index of the first hit |
| cfg_weight_i | input | WGT_W | Weight added per hit |
| thresh_i | input | ACC_W | Report threshold; a location passes when its sum is strictly greater |
| restart_i | input | 1 | Return the block counter to base 0 |
| go_i | input | 1 | Inject the next block this cycle |
| out_valid_o | output | 1 | A finished block is presented |
| out_base_o | output | IDX_W | Base index of the presented block |
| out_mask_o | output | LANES | Bit l set: location base+l passed |

## Verification
The hardest situation to reach is a single block in which one progression lands several hits, another progression hits some of the same lines, and the sum crosses the saturation point. All three must resolve in one cycle at one station. The stimulus sets small intervals (2 and 3) that share locations, and it loads every slot of every station with interval 2 and the largest weight. The unsaturated total would then wrap to a value below the threshold, and that difference exposes any wrap. A bench-side model sums the weights per location from the written configuration. It compares every output block with that model. Separate directed runs pin down the one-block latency and the base counter's return to zero after a restart.

// File: rtl/sieve_pkg.sv
package sieve_pkg;
  localparam int unsigned DEF_LANES    = 8;
  localparam int unsigned DEF_STATIONS = 3;
  localparam int unsigned DEF_PROGS    = 2;
  localparam int unsigned DEF_IDX_W    = 16;
  localparam int unsigned DEF_WGT_W    = 6;
  localparam int unsigned DEF_ACC_W    = 8;
  localparam int unsigned DEF_MAX_HITS = 4;

  function automatic int unsigned sel_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sieve_hit_gen.sv
// Resolves up to MAX_HITS hits of one progression inside the passing block.
module sieve_hit_gen #(
  parameter int unsigned LANES    = 8,
  parameter int unsigned IDX_W    = 16,
  parameter int unsigned WGT_W    = 6,
  parameter int unsigned MAX_HITS = 4
) (
  input  logic                         blk_v_i,
  input  logic [IDX_W-1:0]             base_i,
  input  logic [IDX_W-1:0]             nh_i,
  input  logic [IDX_W-1:0]             p_i,
  input  logic [WGT_W-1:0]             w_i,
  output logic [LANES-1:0][WGT_W-1:0]  lane_w_o,
  output logic [IDX_W-1:0]             nh_next_o
);
  localparam int unsigned LANE_W = $clog2(LANES);

  logic [IDX_W-1:0] cur;
  logic [IDX_W:0]   lo, hi;
  logic             in_blk;

  always_comb begin
    lane_w_o = '0;
    cur      = nh_i;
    lo       = {1'b0, base_i};
    hi       = {1'b0, base_i} + (IDX_W+1)'(LANES);
    in_blk   = 1'b0;
    for (int m = 0; m < int'(MAX_HITS); m++) begin
      in_blk = blk_v_i && ({1'b0, cur} >= lo) && ({1'b0, cur} < hi);
      if (in_blk) begin
        lane_w_o[cur[LANE_W-1:0]] = w_i;
        cur = cur + p_i;
      end
    end
    nh_next_o = cur;
  end
endmodule

// File: rtl/sieve_station.sv
module sieve_station #(
  parameter int unsigned LANES    = 8,
  parameter int unsigned N_PROGS  = 2,
  parameter int unsigned IDX_W    = 16,
  parameter int unsigned WGT_W    = 6,
  parameter int unsigned ACC_W    = 8,
  parameter int unsigned MAX_HITS = 4,
  localparam int unsigned SLOT_W  = sieve_pkg::sel_w(N_PROGS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_we_i,
  input  logic [SLOT_W-1:0]            cfg_slot_i,
  input  logic [IDX_W-1:0]             cfg_p_i,
  input  logic [IDX_W-1:0]             cfg_f_i,
  input  logic [WGT_W-1:0]             cfg_w_i,
  input  logic                         in_v_i,
  input  logic [IDX_W-1:0]             in_base_i,
  input  logic [LANES-1:0][ACC_W-1:0]  in_acc_i,
  output logic                         out_v_o,
  output logic [IDX_W-1:0]             out_base_o,
  output logic [LANES-1:0][ACC_W-1:0]  out_acc_o
);
  logic [N_PROGS-1:0][LANES-1:0][WGT_W-1:0] lane_w;
  logic [LANES-1:0][ACC_W-1:0]              acc_nxt;

  for (genvar k = 0; k < N_PROGS; k++) begin : g_prog
    logic [IDX_W-1:0] p_q, nh_q, nh_nxt;
    logic [WGT_W-1:0] w_q;
    logic             wr;

    assign wr = cfg_we_i && (cfg_slot_i == SLOT_W'(k));

    sieve_hit_gen #(
      .LANES(LANES), .IDX_W(IDX_W), .WGT_W(WGT_W), .MAX_HITS(MAX_HITS)
    ) u_hit (
      .blk_v_i  (in_v_i),
      .base_i   (in_base_i),
      .nh_i     (nh_q),
      .p_i      (p_q),
      .w_i      (w_q),
      .lane_w_o (lane_w[k]),
      .nh_next_o(nh_nxt)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        p_q  <= IDX_W'(LANES);
        nh_q <= '0;
        w_q  <= '0;
      end else if (wr) begin
        p_q  <= cfg_p_i;
        nh_q <= cfg_f_i;
        w_q  <= cfg_w_i;
      end else begin
        nh_q <= nh_nxt;
      end
    end
  end

  logic [ACC_W-1:0] s;
  logic [ACC_W:0]   t;
  always_comb begin
    acc_nxt = '0;
    s = '0;
    t = '0;
    for (int l = 0; l < int'(LANES); l++) begin
      s = in_acc_i[l];
      for (int k = 0; k < int'(N_PROGS); k++) begin
        t = {1'b0, s} + (ACC_W+1)'(lane_w[k][l]);
        s = t[ACC_W] ? '1 : t[ACC_W-1:0];
      end
      acc_nxt[l] = s;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_o    <= 1'b0;
      out_base_o <= '0;
      out_acc_o  <= '0;
    end else begin
      out_v_o    <= in_v_i;
      out_base_o <= in_base_i;
      out_acc_o  <= in_v_i ? acc_nxt : '0;
    end
  end
endmodule

// File: rtl/sieve_report.sv
module sieve_report #(
  parameter int unsigned LANES = 8,
  parameter int unsigned IDX_W = 16,
  parameter int unsigned ACC_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         in_v_i,
  input  logic [IDX_W-1:0]             in_base_i,
  input  logic [LANES-1:0][ACC_W-1:0]  in_acc_i,
  input  logic [ACC_W-1:0]             thresh_i,
  output logic                         out_valid_o,
  output logic [IDX_W-1:0]             out_base_o,
  output logic [LANES-1:0]             out_mask_o
);
  logic [LANES-1:0] pass;
  for (genvar l = 0; l < LANES; l++) begin : g_cmp
    assign pass[l] = in_v_i && (in_acc_i[l] > thresh_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_base_o  <= '0;
      out_mask_o  <= '0;
    end else begin
      out_valid_o <= in_v_i;
      out_base_o  <= in_base_i;
      out_mask_o  <= pass;
    end
  end
endmodule

// File: rtl/sieve_pipe_top.sv
module sieve_pipe_top #(
  parameter int unsigned LANES      = sieve_pkg::DEF_LANES,
  parameter int unsigned N_STATIONS = sieve_pkg::DEF_STATIONS,
  parameter int unsigned N_PROGS    = sieve_pkg::DEF_PROGS,
  parameter int unsigned IDX_W      = sieve_pkg::DEF_IDX_W,
  parameter int unsigned WGT_W      = sieve_pkg::DEF_WGT_W,
  parameter int unsigned ACC_W      = sieve_pkg::DEF_ACC_W,
  parameter int unsigned MAX_HITS   = sieve_pkg::DEF_MAX_HITS,
  localparam int unsigned STA_W     = sieve_pkg::sel_w(N_STATIONS),
  localparam int unsigned SLOT_W    = sieve_pkg::sel_w(N_PROGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [STA_W-1:0]   cfg_sta_i,
  input  logic [SLOT_W-1:0]  cfg_slot_i,
  input  logic [IDX_W-1:0]   cfg_interval_i,
  input  logic [IDX_W-1:0]   cfg_first_i,
  input  logic [WGT_W-1:0]   cfg_weight_i,
  input  logic [ACC_W-1:0]   thresh_i,
  input  logic               restart_i,
  input  logic               go_i,
  output logic               out_valid_o,
  output logic [IDX_W-1:0]   out_base_o,
  output logic [LANES-1:0]   out_mask_o
);
  logic [N_STATIONS:0]                        stg_v;
  logic [N_STATIONS:0][IDX_W-1:0]             stg_base;
  logic [N_STATIONS:0][LANES-1:0][ACC_W-1:0]  stg_acc;
  logic [IDX_W-1:0]                           cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (go_i)      cnt_q <= cnt_q + IDX_W'(LANES);
  end

  assign stg_v[0]    = go_i && !restart_i;
  assign stg_base[0] = cnt_q;
  assign stg_acc[0]  = '0;

  for (genvar j = 0; j < N_STATIONS; j++) begin : g_sta
    logic sel;
    assign sel = cfg_we_i && (cfg_sta_i == STA_W'(j));

    sieve_station #(
      .LANES(LANES), .N_PROGS(N_PROGS), .IDX_W(IDX_W),
      .WGT_W(WGT_W), .ACC_W(ACC_W), .MAX_HITS(MAX_HITS)
    ) u_sta (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_we_i  (sel),
      .cfg_slot_i(cfg_slot_i),
      .cfg_p_i   (cfg_interval_i),
      .cfg_f_i   (cfg_first_i),
      .cfg_w_i   (cfg_weight_i),
      .in_v_i    (stg_v[j]),
      .in_base_i (stg_base[j]),
      .in_acc_i  (stg_acc[j]),
      .out_v_o   (stg_v[j+1]),
      .out_base_o(stg_base[j+1]),
      .out_acc_o (stg_acc[j+1])
    );
  end

  sieve_report #(.LANES(LANES), .IDX_W(IDX_W), .ACC_W(ACC_W)) u_rep (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_v_i     (stg_v[N_STATIONS]),
    .in_base_i  (stg_base[N_STATIONS]),
    .in_acc_i   (stg_acc[N_STATIONS]),
    .thresh_i   (thresh_i),
    .out_valid_o(out_valid_o),
    .out_base_o (out_base_o),
    .out_mask_o (out_mask_o)
  );
endmodule

// File: rtl/sieve_pipe_chk.sv
module sieve_pipe_chk #(
  parameter int unsigned LANES      = 8,
  parameter int unsigned N_STATIONS = 3,
  parameter int unsigned IDX_W      = 16,
  parameter int unsigned ACC_W      = 8
) (
  input logic                                       clk_i,
  input logic                                       rst_ni,
  input logic                                       restart_i,
  input logic                                       out_valid_o,
  input logic [IDX_W-1:0]                           out_base_o,
  input logic [LANES-1:0]                           out_mask_o,
  input logic [N_STATIONS:0]                        stg_v,
  input logic [N_STATIONS:0][IDX_W-1:0]             stg_base,
  input logic [N_STATIONS:0][LANES-1:0][ACC_W-1:0]  stg_acc
);
  localparam int unsigned LANE_W = $clog2(LANES);

  a_r11_mask_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (out_mask_o == '0));

  a_r2_base_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_base_o[LANE_W-1:0] == '0));

  a_r2_base_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(out_valid_o)) |-> (out_base_o == $past(out_base_o) + IDX_W'(LANES)));

  a_r12_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(restart_i) |-> (stg_base[0] == '0));

  for (genvar k = 0; k < N_STATIONS; k++) begin : g_stage
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stg_v[k+1] |-> (stg_acc[k+1][l] >= $past(stg_acc[k][l])));
    end
  end
endmodule

bind sieve_pipe_top sieve_pipe_chk #(
  .LANES(LANES), .N_STATIONS(N_STATIONS), .IDX_W(IDX_W), .ACC_W(ACC_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .restart_i  (restart_i),
  .out_valid_o(out_valid_o),
  .out_base_o (out_base_o),
  .out_mask_o (out_mask_o),
  .stg_v      (stg_v),
  .stg_base   (stg_base),
  .stg_acc    (stg_acc)
);

// File: tb/sieve_pipe_top_tb_top.sv
`timescale 1ns/1ps
module sieve_pipe_top_tb_top;
  localparam int LANES = 8, NST = 3, NPR = 2, IDX_W = 16, WGT_W = 6, ACC_W = 8;
  localparam int STA_W = 2, SLOT_W = 1;
  localparam int ACC_MAX = (1 << ACC_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [STA_W-1:0] cfg_sta = '0;
  logic [SLOT_W-1:0] cfg_slot = '0;
  logic [IDX_W-1:0] cfg_p = '0, cfg_f = '0;
  logic [WGT_W-1:0] cfg_w = '0;
  logic [ACC_W-1:0] thresh = '0;
  logic restart = 1'b0, go = 1'b0;
  logic out_valid;
  logic [IDX_W-1:0] out_base;
  logic [LANES-1:0] out_mask;

  always #2.5 clk = ~clk;

  sieve_pipe_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sta_i(cfg_sta),
    .cfg_slot_i(cfg_slot), .cfg_interval_i(cfg_p), .cfg_first_i(cfg_f),
    .cfg_weight_i(cfg_w), .thresh_i(thresh), .restart_i(restart), .go_i(go),
    .out_valid_o(out_valid), .out_base_o(out_base), .out_mask_o(out_mask)
  );

  int errs = 0, checks = 0, exp_base = 0, blk_seen = 0;
  bit done = 0;
  string tag = "R5";
  int m_p[NST][NPR], m_f[NST][NPR], m_w[NST][NPR];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [LANES-1:0] exp_mask(int base);
    logic [LANES-1:0] m = '0;
    for (int l = 0; l < LANES; l++) begin
      int a = base + l, sum = 0;
      for (int s = 0; s < NST; s++)
        for (int k = 0; k < NPR; k++)
          if (a >= m_f[s][k] && ((a - m_f[s][k]) % m_p[s][k]) == 0) sum += m_w[s][k];
      if (sum > ACC_MAX) sum = ACC_MAX;
      m[l] = (sum > int'(thresh));
    end
    return m;
  endfunction

  // Monitor: every presented block against the model (R2, R4, R5, R9 and scenario tag)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      chk(int'(out_base) == exp_base, "R2", "block base", int'(out_base), exp_base);
      chk(out_mask == exp_mask(exp_base), tag, "pass mask (R4 R9)", int'(out_mask),
          int'(exp_mask(exp_base)));
      exp_base += LANES;
      blk_seen++;
    end
  end

  task automatic cfg(int s, int k, int p, int f, int w);
    @(negedge clk);
    cfg_we = 1; cfg_sta = STA_W'(s); cfg_slot = SLOT_W'(k);
    cfg_p = IDX_W'(p); cfg_f = IDX_W'(f); cfg_w = WGT_W'(w);
    m_p[s][k] = p; m_f[s][k] = f; m_w[s][k] = w;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clear_all();
    for (int s = 0; s < NST; s++)
      for (int k = 0; k < NPR; k++) cfg(s, k, LANES, 0, 0);
  endtask

  task automatic do_restart();
    @(negedge clk);
    restart = 1; go = 0;
    @(negedge clk);
    restart = 0;
    exp_base = 0; blk_seen = 0;
  endtask

  task automatic run(int n, int thr);
    thresh = ACC_W'(thr);
    do_restart();
    go = 1;
    repeat (n) @(negedge clk);
    go = 0;
    repeat (NST + 3) @(negedge clk);
    chk(blk_seen == n, "R2", "blocks out", blk_seen, n);
    chk(!out_valid && out_mask == '0, "R11", "idle mask", int'(out_mask), 0);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1", "valid in reset", int'(out_valid), 0);
    chk(out_mask == '0, "R1", "mask in reset", int'(out_mask), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid, "R1", "valid after reset", int'(out_valid), 0);
    for (int s = 0; s < NST; s++)
      for (int k = 0; k < NPR; k++) begin
        m_p[s][k] = LANES; m_f[s][k] = 0; m_w[s][k] = 0;
      end
  endtask

  task automatic t_single();   // R4 R5: one sparse progression
    tag = "R5";
    clear_all();
    cfg(1, 0, 11, 5, 10);
    run(14, 5);
  endtask

  task automatic t_small();    // R6 R7: several hits per block, same station
    tag = "R6";
    clear_all();
    cfg(0, 0, 2, 1, 4);
    cfg(0, 1, 3, 0, 4);
    run(10, 5);
    tag = "R6";
    clear_all();
    cfg(2, 1, 2, 0, 9);
    run(6, 0);
  endtask

  task automatic t_cross();    // R7: stations add
    tag = "R7";
    clear_all();
    cfg(0, 0, 5, 0, 20);
    cfg(2, 1, 7, 3, 20);
    run(12, 30);
  endtask

  task automatic t_sat();      // R8: six full weights on even locations
    tag = "R8";
    clear_all();
    for (int s = 0; s < NST; s++)
      for (int k = 0; k < NPR; k++) cfg(s, k, 2, 0, 63);
    run(4, 254);
    for (int s = 0; s < NST; s++)
      for (int k = 0; k < NPR; k++) cfg(s, k, 2, 0, 63);
    run(4, 255);
  endtask

  task automatic t_thresh();   // R9: strict compare
    tag = "R9";
    clear_all();
    cfg(1, 1, 3, 0, 10);
    run(3, 10);
    cfg(1, 1, 3, 0, 10);
    run(3, 9);
  endtask

  task automatic t_cfg();      // R10: overwrite and disable
    tag = "R10";
    clear_all();
    cfg(1, 0, 3, 0, 40);
    cfg(1, 1, 5, 0, 40);
    cfg(1, 1, 5, 0, 0);
    run(6, 30);
  endtask

  task automatic t_latency();  // R3 R12
    tag = "R3";
    clear_all();
    cfg(0, 0, 2, 0, 10);
    thresh = ACC_W'(5);
    do_restart();
    @(negedge clk);
    go = 1;
    @(negedge clk);
    go = 0;
    for (int j = 0; j <= NST; j++) begin
      chk(out_valid == (j == NST), "R3", "valid vs edges after inject", int'(out_valid),
          int'(j == NST));
      if (j == NST) chk(out_base == '0, "R12", "base after restart", int'(out_base), 0);
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog (all R): actual=timeout expected=completion");
    summary();
  end

  initial begin
    t_reset();
    t_single();
    t_small();
    t_cross();
    t_sat();
    t_thresh();
    t_cfg();
    t_latency();
    summary();
  end
endmodule